// File: doc/BRIEF.md
# LCD power-up command sequencer

This block drives the power-up of a small TFT panel controller. After reset, or after a start pulse, it plays a fixed script of 36 steps. A step is a command byte, a parameter byte or a timed pause. Bytes leave on a valid/ready stream that carries a data/command flag and an 8-bit value, meant for a serial word transmitter that sends each byte as a 9-bit word. Pauses count pulses of a 1 ms tick input.

The script starts by unlocking the vendor-extended command set. It then wakes the panel from sleep and sets the oscillator, drive strength, VCOM and power control. Next it picks a 16-bit pixel format and finally switches the display on. A done flag rises once the last pause has run out. It stays high until the next start pulse.

Top module: `lcd_init_seq`

## Requirements
- R1: One cycle after reset is released, the block presents command C1h: `out_valid`=1, `out_dc`=0, `out_byte`=C1h, `done`=0.
- R2: The bytes accepted on the stream, in order, are: C1h, FFh, 83h, 40h, 11h, CAh, 70h, 00h, D9h, B0h, 01h, 11h, C9h, 90h, 49h, 10h, 28h, 28h, 10h, 00h, 06h, B5h, 35h, 20h, 45h, B4h, 33h, 25h, 4Ch, 3Ah, 55h, 29h. The command bytes (C1h, 11h, CAh, B0h, C9h, B5h, B4h, 3Ah, 29h at their places in that order) carry `out_dc`=0. Every other byte carries `out_dc`=1. A byte is accepted on a clock edge where `out_valid` and `out_ready` are both high.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_dc` and `out_byte` keep their values on the next cycle, unless `start` is high.
- R4: Between acceptance of the sleep-out command 11h and the appearance of CAh, exactly 150 tick pulses are consumed.
- R5: Exactly 20 ticks are consumed after the last C9h parameter (06h), exactly 10 after the last B4h parameter (4Ch), and exactly 10 after display-on 29h before `done` rises.
- R6: A tick is consumed only when it is sampled on an edge after the preceding byte was accepted and while `out_valid` is low. Ticks that arrive while a byte is waiting for `out_ready` have no effect. Without a tick pulse, a pause never ends.
- R7: Once high, `done` stays high and `out_valid` stays low until `start` is pulsed.
- R8: A `start` pulse at any point restarts the script from its first step: on the next cycle `out_valid`=1, `out_dc`=0, `out_byte`=C1h and `done`=0. This holds during a pause, partway through the bytes, and after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Restart the script from step 0 |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| out_ready | input | 1 | Downstream transmitter accepts a byte |
| out_valid | output | 1 | A script byte is presented |
| out_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| out_byte | output | 8 | Byte value |
| done | output | 1 | Script finished |

## Verification
The hardest case is a tick that lands on the exact edge where a pause step is first reached, right after the previous byte was accepted. A second hard case is a tick that arrives while a byte is stalled by `out_ready`. Both are easy to miss with sparse stimulus. The bench runs the script with random ready and tick patterns and counts only the ticks it drove while `out_valid` was low. It also runs one pass with a tick on every cycle and ready always high, so that each pause is entered on a tick edge. It holds ready low while ticking to show that stalled bytes ignore the tick, and it restarts the script inside the 150 ms pause.

// File: rtl/lcd_init_seq.sv
module lcd_init_seq #(
  parameter int STEP_W = 6,
  parameter int WAIT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick_1ms,
  input  logic       out_ready,
  output logic       out_valid,
  output logic       out_dc,
  output logic [7:0] out_byte,
  output logic       done
);
  localparam int NUM_STEPS = 36;
  localparam logic [1:0] K_CMD  = 2'd0;
  localparam logic [1:0] K_PAR  = 2'd1;
  localparam logic [1:0] K_WAIT = 2'd2;

  function automatic logic [9:0] script(input logic [STEP_W-1:0] idx);
    case (int'(idx))
      0:  script = {K_CMD,  8'hC1};
      1:  script = {K_PAR,  8'hFF};
      2:  script = {K_PAR,  8'h83};
      3:  script = {K_PAR,  8'h40};
      4:  script = {K_CMD,  8'h11};
      5:  script = {K_WAIT, 8'd150};
      6:  script = {K_CMD,  8'hCA};
      7:  script = {K_PAR,  8'h70};
      8:  script = {K_PAR,  8'h00};
      9:  script = {K_PAR,  8'hD9};
      10: script = {K_CMD,  8'hB0};
      11: script = {K_PAR,  8'h01};
      12: script = {K_PAR,  8'h11};
      13: script = {K_CMD,  8'hC9};
      14: script = {K_PAR,  8'h90};
      15: script = {K_PAR,  8'h49};
      16: script = {K_PAR,  8'h10};
      17: script = {K_PAR,  8'h28};
      18: script = {K_PAR,  8'h28};
      19: script = {K_PAR,  8'h10};
      20: script = {K_PAR,  8'h00};
      21: script = {K_PAR,  8'h06};
      22: script = {K_WAIT, 8'd20};
      23: script = {K_CMD,  8'hB5};
      24: script = {K_PAR,  8'h35};
      25: script = {K_PAR,  8'h20};
      26: script = {K_PAR,  8'h45};
      27: script = {K_CMD,  8'hB4};
      28: script = {K_PAR,  8'h33};
      29: script = {K_PAR,  8'h25};
      30: script = {K_PAR,  8'h4C};
      31: script = {K_WAIT, 8'd10};
      32: script = {K_CMD,  8'h3A};
      33: script = {K_PAR,  8'h55};
      34: script = {K_CMD,  8'h29};
      35: script = {K_WAIT, 8'd10};
      default: script = {K_WAIT, 8'd0};
    endcase
  endfunction

  logic [STEP_W-1:0] step;
  logic              pausing;
  logic [WAIT_W-1:0] remain;

  logic [9:0]        entry;
  logic [1:0]        kind;
  logic [WAIT_W-1:0] span;
  logic              at_end;

  assign entry  = script(step);
  assign kind   = entry[9:8];
  assign span   = WAIT_W'(entry[7:0]);
  assign at_end = (step == STEP_W'(NUM_STEPS));

  assign out_valid = !at_end && (kind != K_WAIT);
  assign out_dc    = (kind == K_PAR);
  assign out_byte  = entry[7:0];
  assign done      = at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      step    <= '0;
      pausing <= 1'b0;
      remain  <= '0;
    end else if (!at_end) begin
      if (pausing) begin
        if (tick_1ms) begin
          if (remain <= WAIT_W'(1)) begin
            pausing <= 1'b0;
            step    <= step + 1'b1;
          end else begin
            remain <= remain - 1'b1;
          end
        end
      end else if (kind == K_WAIT) begin
        if (span == '0 || (tick_1ms && span == WAIT_W'(1))) begin
          step <= step + 1'b1;
        end else begin
          pausing <= 1'b1;
          remain  <= span - WAIT_W'(tick_1ms);
        end
      end else if (out_ready) begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       tick_1ms,
  input logic       out_ready,
  input logic       out_valid,
  input logic       out_dc,
  input logic [7:0] out_byte,
  input logic       done
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_byte) && $stable(out_dc));

  assert_wake_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !done && !tick_1ms && !start |=> !out_valid);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid && !out_dc && out_byte == 8'hC1 && !done);
endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (.*);

// File: tb/tb_lcd_init_seq.sv
`timescale 1ns/1ps
module tb_lcd_init_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, tick_1ms = 1'b0, out_ready = 1'b0;
  logic out_valid, out_dc, done;
  logic [7:0] out_byte;

  lcd_init_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .tick_1ms(tick_1ms),
    .out_ready(out_ready), .out_valid(out_valid), .out_dc(out_dc),
    .out_byte(out_byte), .done(done));

  int checks = 0, fails = 0, cycles = 0;
  int bidx = 0, tick_cnt = 0;
  bit done_seen = 0, hold_pend = 0;
  logic [8:0] hold_val;

  function automatic logic [8:0] exp_byte(int k);
    logic [7:0] v [32] = '{8'hC1,8'hFF,8'h83,8'h40,8'h11,8'hCA,8'h70,8'h00,8'hD9,
      8'hB0,8'h01,8'h11,8'hC9,8'h90,8'h49,8'h10,8'h28,8'h28,8'h10,8'h00,8'h06,
      8'hB5,8'h35,8'h20,8'h45,8'hB4,8'h33,8'h25,8'h4C,8'h3A,8'h55,8'h29};
    bit cmd;
    cmd = (k==0 || k==4 || k==5 || k==9 || k==12 || k==21 || k==25 || k==29 || k==31);
    return {~cmd, v[k]};
  endfunction

  function automatic int exp_wait(int k);
    case (k)
      5: return 150;
      21: return 20;
      29: return 10;
      32: return 10;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit rdy, bit tk, bit st);
    @(negedge clk);
    if (hold_pend)
      chk(out_valid && {out_dc, out_byte} == hold_val, "R3/R6", "stalled byte changed",
          int'({out_valid, out_dc, out_byte}), int'({1'b1, hold_val}));
    out_ready = rdy; tick_1ms = st ? 1'b0 : tk; start = st;
    if (st) begin
      bidx = 0; tick_cnt = 0; done_seen = 0; hold_pend = 0;
      return;
    end
    if (tick_1ms && !out_valid && !done) tick_cnt++;
    if (done && !done_seen) begin
      chk(bidx == 32, "R2", "bytes before done", bidx, 32);
      chk(tick_cnt == exp_wait(32), "R5", "ticks after 29h", tick_cnt, 10);
      done_seen = 1;
    end else if (done_seen) begin
      chk(done && !out_valid, "R7", "done/valid after finish", int'({done, out_valid}), 2);
    end
    if (out_valid && rdy) begin
      chk({out_dc, out_byte} == exp_byte(bidx), "R2", $sformatf("byte %0d", bidx),
          int'({out_dc, out_byte}), int'(exp_byte(bidx)));
      if (exp_wait(bidx) != 0)
        chk(tick_cnt == exp_wait(bidx), bidx == 5 ? "R4" : "R5/R6",
            $sformatf("ticks before byte %0d", bidx), tick_cnt, exp_wait(bidx));
      bidx++; tick_cnt = 0;
    end
    hold_pend = out_valid && !rdy;
    hold_val = {out_dc, out_byte};
  endtask

  task automatic run_rand(int pct);
    cyc($urandom_range(3) != 0, $urandom_range(99) < pct, 0);
  endtask

  task automatic restart_check(string where);
    cyc(0, 0, 1);
    @(negedge clk);
    chk(out_valid && !out_dc && out_byte == 8'hC1 && !done, "R8", where,
        int'({out_valid, out_dc, out_byte, done}), int'({1'b1, 1'b0, 8'hC1, 1'b0}));
  endtask

  task automatic reset_check();
    @(negedge clk); rst_n = 0; out_ready = 0; tick_1ms = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid && !out_dc && out_byte == 8'hC1 && !done, "R1", "state after reset",
        int'({out_valid, out_dc, out_byte, done}), int'({1'b1, 1'b0, 8'hC1, 1'b0}));
    bidx = 0; tick_cnt = 0; done_seen = 0; hold_pend = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    reset_check();
    while (!done_seen) run_rand(30);
    repeat (40) run_rand(50);
    restart_check("restart after done");

    while (bidx < 3) run_rand(30);
    restart_check("restart among parameters");

    while (bidx < 5) run_rand(30);
    repeat (20) run_rand(40);
    restart_check("restart inside 150 ms pause");

    repeat (12) cyc(0, 1, 0);
    while (!done_seen) cyc(1, 1, 0);
    repeat (5) cyc(1, 1, 0);

    restart_check("restart before directed stalls");
    while (!done_seen) begin
      if (out_valid) repeat (2) cyc(0, 1, 0);
      cyc(1, $urandom_range(99) < 20, 0);
    end

    reset_check();
    while (bidx < 10) run_rand(30);
    reset_check();
    while (!done_seen) run_rand(60);
    repeat (10) run_rand(50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule